// File: doc/BRIEF.md
# Protected Watchdog Timer

This block is a watchdog for a small microcontroller. A free-running counter runs on a dedicated slow clock that is separate from the bus clock. If software stops restarting it, the counter wraps and the block sends a reset pulse to the system. Software reaches the block through a byte-wide register port with three addresses: a control register, a configuration register and a key register.

A write to the control register takes effect only directly after an unlock sequence. This keeps a runaway program from switching the watchdog off or restarting it. Bit 7 of the control register turns the slow oscillator and the counter on. Bit 0 is a one-shot request that restarts the count. The enable level and the restart request cross into the slow domain through two-flop synchronizers. The restart request is carried as a toggle, so each request is seen exactly once.

A wrap in the slow domain comes back to the bus domain as a toggle and is stretched into a reset pulse of fixed length. The same event sets a reset-cause flag in the configuration register. The flag keeps its value through system resets and is lost only at power-on or when software clears it.

Top module: `wdg_ctrl`

## Requirements
- R1: After power-on reset, the control register (address 0) and the configuration register (address 1) both read 0x00, and `wdt_rst` and `osc_run` are low.
- R2: A control write is accepted only after a write of 0xAA and then a write of 0x55 to the key register (address 2), with no other write between them. The control write must come within UNLOCK_WIN bus cycles after the 0x55 write (default 4, so up to 3 idle cycles between them are allowed).
- R3: The unlock is cancelled by a key write in the wrong order, by any other write between the two key writes, or by a control write that comes later than UNLOCK_WIN cycles. One accepted control write uses up the unlock, so a second control write is ignored.
- R4: Control bit 7 is the enable and reads back as written. `osc_run` follows it. Control bit 0 is the restart strobe and always reads 0.
- R5: Once enabled, the counter raises `wdt_rst` between 2^CNT_W and 2^CNT_W+8 slow-clock cycles after the accepted enable write.
- R6: An accepted write with bit 0 set zeroes the counter. The next wrap then comes between 2^CNT_W and 2^CNT_W+8 slow cycles after that write. Restarting more often than that keeps `wdt_rst` low.
- R7: Each `wdt_rst` pulse lasts exactly PULSE_LEN bus cycles (default 4).
- R8: The enable bit returns to 0 after a watchdog pulse and after `sys_rst_n` is asserted.
- R9: A watchdog pulse sets configuration bit 6. The bit stays set through `sys_rst_n`. Writing 1 to it has no effect. Writing 0 to it clears it. A power-on reset clears it.
- R10: While the enable is 0 the counter stays at zero, so enabling again always starts a full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus and register clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| sys_rst_n | input | 1 | System reset, active low, does not clear the cause flag |
| wd_clk | input | 1 | Dedicated slow watchdog clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 configuration, 2 key |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| osc_run | output | 1 | Turns on the slow oscillator; equals the enable bit |
| wdt_rst | output | 1 | Watchdog reset pulse in the bus domain |

## Verification
The assertions assume that the two clocks are free-running and unrelated. They also assume that the register port changes only away from the bus clock edge, and that each write lasts exactly one bus cycle. The bench drives every bus signal on the falling edge and holds each write for a single cycle. Its restart intervals stay far from one full period of the counter, so a wrap never lands in the middle of a restart crossing. The wrap time depends on the synchronizer phase, so it is checked against a window of slow-clock cycles rather than a single cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_CTRL = 2'd0,
    REG_CFG  = 2'd1,
    REG_KEY  = 2'd2
  } reg_sel_e;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  localparam int unsigned CTRL_EN_BIT  = 7;
  localparam int unsigned CTRL_CLR_BIT = 0;
  localparam int unsigned CFG_FLAG_BIT = 6;
endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= 1'b0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= 1'b0;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wdg_unlock.sv
module wdg_unlock
  import wdg_pkg::*;
#(
  parameter int unsigned WIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              open
);
  localparam int unsigned CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] WIN_LOAD = CW'(WIN);
  localparam logic [CW-1:0] WIN_LAST = CW'(1);

  typedef enum logic [1:0] {LK_IDLE, LK_HALF, LK_OPEN} lk_e;

  lk_e           st_q, st_d;
  logic [CW-1:0] win_q, win_d;
  logic          key_wr;

  assign key_wr = wr_en && (addr == REG_KEY);

  always_comb begin
    st_d  = st_q;
    win_d = win_q;
    if (abort) begin
      st_d  = LK_IDLE;
      win_d = '0;
    end else begin
      case (st_q)
        LK_IDLE: begin
          if (key_wr && wdata == KEY_FIRST) st_d = LK_HALF;
        end
        LK_HALF: begin
          if (wr_en) begin
            if (key_wr && wdata == KEY_SECOND) begin
              st_d  = LK_OPEN;
              win_d = WIN_LOAD;
            end else if (key_wr && wdata == KEY_FIRST) begin
              st_d = LK_HALF;
            end else begin
              st_d = LK_IDLE;
            end
          end
        end
        LK_OPEN: begin
          if (wr_en || win_q == WIN_LAST) begin
            st_d  = LK_IDLE;
            win_d = '0;
          end else begin
            win_d = win_q - 1'b1;
          end
        end
        default: st_d = LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LK_IDLE;
      win_q <= '0;
    end else begin
      st_q  <= st_d;
      win_q <= win_d;
    end
  end

  assign open = (st_q == LK_OPEN);
endmodule

// File: rtl/wdg_core.sv
module wdg_core #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SYNC_N = 2
) (
  input  logic wd_clk,
  input  logic wd_rst_n,
  input  logic en_async,
  input  logic clr_tog_async,
  output logic ovf_tog
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic             en_s, tog_s;
  logic             tog_seen_q, tog_seen_d;
  logic             clr_hit;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;

  wdg_sync #(.STAGES(SYNC_N)) u_en_sync (
    .clk(wd_clk), .rst_n(wd_rst_n), .d(en_async), .q(en_s)
  );
  wdg_sync #(.STAGES(SYNC_N)) u_clr_sync (
    .clk(wd_clk), .rst_n(wd_rst_n), .d(clr_tog_async), .q(tog_s)
  );

  assign clr_hit = tog_s ^ tog_seen_q;

  always_comb begin
    tog_seen_d = tog_s;
    ovf_d      = ovf_q;
    if (!en_s || clr_hit) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_TOP) ovf_d = ~ovf_q;
    end
  end

  always_ff @(posedge wd_clk or negedge wd_rst_n) begin
    if (!wd_rst_n) begin
      tog_seen_q <= 1'b0;
      cnt_q      <= '0;
      ovf_q      <= 1'b0;
    end else begin
      tog_seen_q <= tog_seen_d;
      cnt_q      <= cnt_d;
      ovf_q      <= ovf_d;
    end
  end

  assign ovf_tog = ovf_q;
endmodule

// File: rtl/wdg_rst_stretch.sv
module wdg_rst_stretch #(
  parameter int unsigned SYNC_N    = 2,
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_tog_async,
  output logic start,
  output logic busy
);
  localparam int unsigned LW = $clog2(PULSE_LEN + 1);
  localparam logic [LW-1:0] LEN_LOAD = LW'(PULSE_LEN - 1);

  logic          ovf_s, seen_q, seen_d;
  logic          busy_q, busy_d;
  logic [LW-1:0] left_q, left_d;

  wdg_sync #(.STAGES(SYNC_N)) u_ovf_sync (
    .clk(clk), .rst_n(rst_n), .d(ovf_tog_async), .q(ovf_s)
  );

  assign start = ovf_s ^ seen_q;

  always_comb begin
    seen_d = ovf_s;
    busy_d = busy_q;
    left_d = left_q;
    if (start) begin
      busy_d = 1'b1;
      left_d = LEN_LOAD;
    end else if (busy_q) begin
      if (left_q == '0) busy_d = 1'b0;
      else              left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      busy_q <= 1'b0;
      left_q <= '0;
    end else begin
      seen_q <= seen_d;
      busy_q <= busy_d;
      left_q <= left_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned SYNC_N     = 2,
  parameter int unsigned UNLOCK_WIN = 4,
  parameter int unsigned PULSE_LEN  = 4
) (
  input  logic              bus_clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              wd_clk,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              osc_run,
  output logic              wdt_rst
);
  logic bus_raw_n, bpor_n, bsys_n, wrst_n;
  logic lk_open, accept, ovf_tog, ovf_start, pulse;
  logic en_q, en_d, clr_tog_q, clr_tog_d, flag_q, flag_d;

  assign bus_raw_n = por_n & sys_rst_n;

  wdg_sync #(.STAGES(SYNC_N)) u_por_rel (
    .clk(bus_clk), .rst_n(por_n), .d(1'b1), .q(bpor_n)
  );
  wdg_sync #(.STAGES(SYNC_N)) u_sys_rel (
    .clk(bus_clk), .rst_n(bus_raw_n), .d(1'b1), .q(bsys_n)
  );
  wdg_sync #(.STAGES(SYNC_N)) u_wd_rel (
    .clk(wd_clk), .rst_n(por_n), .d(1'b1), .q(wrst_n)
  );

  wdg_unlock #(.WIN(UNLOCK_WIN)) u_unlock (
    .clk(bus_clk), .rst_n(bsys_n), .abort(pulse),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .open(lk_open)
  );

  wdg_core #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_core (
    .wd_clk(wd_clk), .wd_rst_n(wrst_n), .en_async(en_q),
    .clr_tog_async(clr_tog_q), .ovf_tog(ovf_tog)
  );

  wdg_rst_stretch #(.SYNC_N(SYNC_N), .PULSE_LEN(PULSE_LEN)) u_stretch (
    .clk(bus_clk), .rst_n(bpor_n), .ovf_tog_async(ovf_tog),
    .start(ovf_start), .busy(pulse)
  );

  assign accept = wr_en && lk_open && (addr == REG_CTRL) && !pulse;

  always_comb begin
    en_d      = en_q;
    clr_tog_d = clr_tog_q;
    flag_d    = flag_q;
    if (pulse)       en_d = 1'b0;
    else if (accept) en_d = wdata[CTRL_EN_BIT];
    if (accept && wdata[CTRL_CLR_BIT]) clr_tog_d = ~clr_tog_q;
    if (ovf_start) flag_d = 1'b1;
    else if (wr_en && addr == REG_CFG && !wdata[CFG_FLAG_BIT]) flag_d = 1'b0;
  end

  always_ff @(posedge bus_clk or negedge bsys_n) begin
    if (!bsys_n) en_q <= 1'b0;
    else         en_q <= en_d;
  end

  always_ff @(posedge bus_clk or negedge bpor_n) begin
    if (!bpor_n) begin
      clr_tog_q <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      clr_tog_q <= clr_tog_d;
      flag_q    <= flag_d;
    end
  end

  always_comb begin
    rdata = 8'h00;
    case (addr)
      REG_CTRL: rdata[CTRL_EN_BIT]  = en_q;
      REG_CFG:  rdata[CFG_FLAG_BIT] = flag_q;
      default:  rdata = 8'h00;
    endcase
  end

  assign osc_run = en_q;
  assign wdt_rst = pulse;
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk
  import wdg_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 4
) (
  input logic              bus_clk,
  input logic              por_n,
  input logic              sys_rst_n,
  input logic              wr_en,
  input logic [REG_AW-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              unlocked,
  input logic              osc_run,
  input logic              wdt_rst,
  input logic              flag
);
  logic [15:0] run_len;

  always_ff @(posedge bus_clk or negedge por_n) begin
    if (!por_n)       run_len <= '0;
    else if (wdt_rst) run_len <= run_len + 1'b1;
    else              run_len <= '0;
  end

  AST_LOCKED_CTRL: assert property (@(posedge bus_clk) disable iff (!(por_n && sys_rst_n))
    (wr_en && addr == REG_CTRL && !unlocked && !wdt_rst) |=> $stable(osc_run)); // R2

  AST_CLR_READS_ZERO: assert property (@(posedge bus_clk) disable iff (!por_n)
    (addr == REG_CTRL) |-> (rdata[CTRL_CLR_BIT] == 1'b0)); // R4

  AST_PULSE_LEN: assert property (@(posedge bus_clk) disable iff (!por_n)
    $fell(wdt_rst) |-> (run_len == 16'(PULSE_LEN))); // R7

  AST_EN_DROP: assert property (@(posedge bus_clk) disable iff (!por_n)
    wdt_rst |=> !osc_run); // R8

  AST_FLAG_SET: assert property (@(posedge bus_clk) disable iff (!por_n)
    $rose(wdt_rst) |-> flag); // R9

  AST_FLAG_STICKY: assert property (@(posedge bus_clk) disable iff (!por_n)
    (flag && !(wr_en && addr == REG_CFG && !wdata[CFG_FLAG_BIT])) |=> flag); // R9
endmodule

bind wdg_ctrl wdg_chk #(.PULSE_LEN(PULSE_LEN)) i_chk (
  .bus_clk(bus_clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
  .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
  .unlocked(lk_open), .osc_run(osc_run), .wdt_rst(wdt_rst), .flag(flag_q)
);

// File: tb/test_wdg_ctrl.sv
module test_wdg_ctrl;
  localparam int CNT_W = 6;
  localparam int PERIOD = 1 << CNT_W;
  localparam int PLEN = 4;

  logic bus_clk = 1'b0, wd_clk = 1'b0;
  logic por_n, sys_rst_n, wr_en, osc_run, wdt_rst;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;

  int n_tests = 0, n_fail = 0, wd_ticks = 0;
  bit rst_seen = 1'b0, done = 1'b0;

  always #10 bus_clk = ~bus_clk;
  always #45 wd_clk  = ~wd_clk;
  always @(posedge wd_clk) wd_ticks++;
  always @(posedge bus_clk) if (wdt_rst) rst_seen <= 1'b1;

  wdg_ctrl #(.CNT_W(CNT_W), .UNLOCK_WIN(4), .PULSE_LEN(PLEN)) i_wdg_ctrl (
    .bus_clk(bus_clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wd_clk(wd_clk),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .osc_run(osc_run), .wdt_rst(wdt_rst)
  );

  // {req[23:20], op[19:18] 0 idle 1 write 2 read, addr[17:16], data[15:8], expect[7:0]}
  localparam int NV = 46;
  localparam logic [23:0] VEC [NV] = '{
    {4'd1, 2'd2, 2'd0, 8'h00, 8'h00}, {4'd1, 2'd2, 2'd1, 8'h00, 8'h00},
    {4'd2, 2'd1, 2'd0, 8'h80, 8'h00}, {4'd2, 2'd2, 2'd0, 8'h00, 8'h00},
    {4'd2, 2'd1, 2'd2, 8'hAA, 8'h00}, {4'd2, 2'd1, 2'd2, 8'h55, 8'h00},
    {4'd2, 2'd1, 2'd0, 8'h80, 8'h00}, {4'd4, 2'd2, 2'd0, 8'h00, 8'h80},
    {4'd3, 2'd1, 2'd0, 8'h00, 8'h00}, {4'd3, 2'd2, 2'd0, 8'h00, 8'h80},
    {4'd4, 2'd1, 2'd2, 8'hAA, 8'h00}, {4'd4, 2'd1, 2'd2, 8'h55, 8'h00},
    {4'd4, 2'd1, 2'd0, 8'h81, 8'h00}, {4'd4, 2'd2, 2'd0, 8'h00, 8'h80},
    {4'd4, 2'd1, 2'd2, 8'hAA, 8'h00}, {4'd4, 2'd1, 2'd2, 8'h55, 8'h00},
    {4'd4, 2'd1, 2'd0, 8'h00, 8'h00}, {4'd4, 2'd2, 2'd0, 8'h00, 8'h00},
    {4'd3, 2'd1, 2'd2, 8'h55, 8'h00}, {4'd3, 2'd1, 2'd2, 8'hAA, 8'h00},
    {4'd3, 2'd1, 2'd0, 8'h80, 8'h00}, {4'd3, 2'd2, 2'd0, 8'h00, 8'h00},
    {4'd3, 2'd1, 2'd2, 8'hAA, 8'h00}, {4'd3, 2'd1, 2'd1, 8'h00, 8'h00},
    {4'd3, 2'd1, 2'd2, 8'h55, 8'h00}, {4'd3, 2'd1, 2'd0, 8'h80, 8'h00},
    {4'd3, 2'd2, 2'd0, 8'h00, 8'h00}, {4'd3, 2'd1, 2'd2, 8'hAA, 8'h00},
    {4'd3, 2'd1, 2'd2, 8'h55, 8'h00}, {4'd3, 2'd0, 2'd0, 8'h00, 8'h00},
    {4'd3, 2'd0, 2'd0, 8'h00, 8'h00}, {4'd3, 2'd0, 2'd0, 8'h00, 8'h00},
    {4'd3, 2'd0, 2'd0, 8'h00, 8'h00}, {4'd3, 2'd1, 2'd0, 8'h80, 8'h00},
    {4'd3, 2'd2, 2'd0, 8'h00, 8'h00}, {4'd2, 2'd1, 2'd2, 8'hAA, 8'h00},
    {4'd2, 2'd1, 2'd2, 8'h55, 8'h00}, {4'd2, 2'd0, 2'd0, 8'h00, 8'h00},
    {4'd2, 2'd0, 2'd0, 8'h00, 8'h00}, {4'd2, 2'd0, 2'd0, 8'h00, 8'h00},
    {4'd2, 2'd1, 2'd0, 8'h80, 8'h00}, {4'd2, 2'd2, 2'd0, 8'h00, 8'h80},
    {4'd2, 2'd1, 2'd2, 8'hAA, 8'h00}, {4'd2, 2'd1, 2'd2, 8'h55, 8'h00},
    {4'd2, 2'd1, 2'd0, 8'h00, 8'h00}, {4'd2, 2'd2, 2'd0, 8'h00, 8'h00}
  };

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    n_tests++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge bus_clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    wr_en = 1'b0; addr = a;
    #1 check(req, int'(rdata), int'(exp));
    @(negedge bus_clk);
  endtask

  task automatic ctrl_wr(input logic [7:0] d);
    bus_wr(2'd2, 8'hAA);
    bus_wr(2'd2, 8'h55);
    bus_wr(2'd0, d);
  endtask

  task automatic wait_ticks(input int n);
    int s = wd_ticks;
    while (wd_ticks - s < n) @(negedge bus_clk);
  endtask

  task automatic wait_rst(input int t0, output int ticks, output int plen);
    int guard = 0;
    while (!wdt_rst && guard < 3000) begin
      @(negedge bus_clk);
      guard++;
    end
    ticks = wd_ticks - t0;
    plen = 0;
    while (wdt_rst) begin
      plen++;
      @(negedge bus_clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge bus_clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int t0, ticks, plen;
    por_n = 1'b0; sys_rst_n = 1'b1; wr_en = 1'b0; addr = 2'd0; wdata = 8'h00;
    repeat (5) @(negedge bus_clk);
    por_n = 1'b1;
    repeat (5) @(negedge bus_clk);
    check("R1 wdt_rst", int'(wdt_rst), 0);
    check("R1 osc_run", int'(osc_run), 0);

    // table walk: R1 reset values, R2 unlock and boundary, R3 cancel cases, R4 readback
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vector %0d", VEC[i][23:20], i);
      case (VEC[i][19:18])
        2'd1:    bus_wr(VEC[i][17:16], VEC[i][15:8]);
        2'd2:    bus_rd(VEC[i][17:16], VEC[i][7:0], tag);
        default: begin wr_en = 1'b0; @(negedge bus_clk); end
      endcase
    end

    // R5 wrap time, R7 pulse length, R8 enable drop, R9 flag set
    ctrl_wr(8'h80);
    check("R4 osc_run on", int'(osc_run), 1);
    t0 = wd_ticks;
    wait_rst(t0, ticks, plen);
    check_range("R5 wrap ticks", ticks, PERIOD, PERIOD + 8);
    check("R7 pulse length", plen, PLEN);
    check("R8 osc_run after pulse", int'(osc_run), 0);
    bus_rd(2'd0, 8'h00, "R8 ctrl after pulse");
    bus_rd(2'd1, 8'h40, "R9 flag set");

    // R8 system reset drops enable, R9 flag survives it
    ctrl_wr(8'h80);
    check("R4 osc_run re-enabled", int'(osc_run), 1);
    sys_rst_n = 1'b0;
    repeat (3) @(negedge bus_clk);
    sys_rst_n = 1'b1;
    repeat (4) @(negedge bus_clk);
    check("R8 osc_run after sys reset", int'(osc_run), 0);
    bus_rd(2'd0, 8'h00, "R8 ctrl after sys reset");
    bus_rd(2'd1, 8'h40, "R9 flag after sys reset");
    bus_wr(2'd1, 8'h40);
    bus_rd(2'd1, 8'h40, "R9 write 1 no effect");
    bus_wr(2'd1, 8'h00);
    bus_rd(2'd1, 8'h00, "R9 write 0 clears");

    // R6 periodic restart keeps reset away, then wrap measured from last restart
    wait_ticks(PERIOD + 12);
    rst_seen = 1'b0;
    ctrl_wr(8'h80);
    for (int k = 0; k < 8; k++) begin
      wait_ticks(40);
      ctrl_wr(8'h81);
    end
    t0 = wd_ticks;
    check("R6 no reset while restarted", int'(rst_seen), 0);
    wait_rst(t0, ticks, plen);
    check_range("R6 wrap after last restart", ticks, PERIOD, PERIOD + 8);

    // R10 disabled counter holds zero
    wait_ticks(PERIOD + 12);
    rst_seen = 1'b0;
    ctrl_wr(8'h80);
    wait_ticks(40);
    ctrl_wr(8'h00);
    wait_ticks(10);
    ctrl_wr(8'h80);
    t0 = wd_ticks;
    check("R10 no reset before re-enable", int'(rst_seen), 0);
    wait_rst(t0, ticks, plen);
    check_range("R10 full period after re-enable", ticks, PERIOD, PERIOD + 8);
    check("R7 pulse length again", plen, PLEN);

    // R9 power-on reset clears the flag
    bus_rd(2'd1, 8'h40, "R9 flag before por");
    por_n = 1'b0;
    repeat (3) @(negedge bus_clk);
    por_n = 1'b1;
    repeat (5) @(negedge bus_clk);
    bus_rd(2'd1, 8'h00, "R9 flag cleared by por");
    bus_rd(2'd0, 8'h00, "R1 ctrl after por");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule